// File: doc/BRIEF.md
# Sequential Integer Power Unit

This unit raises a W-bit integer base to a W-bit integer exponent over several clock cycles. The result keeps only the low W bits, the same as the power operator of a hardware description language when its result width equals its operand width. Two flags say whether the base and the exponent are to be read as two's-complement values. A one-cycle `start` pulse captures the operands and flags. `busy` stays high while the unit works. A one-cycle `done` pulse marks the cycle in which `result` first shows the new value.

The loop walks the exponent from its least significant bit upward. It keeps a running power, which starts at the base, and an accumulator, which starts at 1. Before each exponent bit after bit 0, the running power is squared. When the bit is set, the accumulator is multiplied by the running power. A single truncating multiplier serves both operations on alternate cycles. The loop stops at the highest set exponent bit. A zero exponent, or a negative signed exponent, is settled by a fixed rule in the cycle after `start` and never enters the loop.

Top module: `int_pow_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `busy`=0, `done`=0 and `result`=0.
- R2: An exponent equal to zero gives `result`=1 for any base, including a base of 0.
- R3: For a non-negative exponent, `result` equals the base raised to the exponent, truncated to W bits. This holds whatever the signedness flags are, as long as the exponent is not negative. For example, 2 to the power W gives 0.
- R4: With W=68, base 0xE123456789ABCDEF0 raised to 3 gives 0xCEE3CB96CE96CF000, and raised to 0x56789ABCDEF012345 gives 0. Both results must hold with both flags clear and with both flags set.
- R5: With the exponent flagged signed and its bit W-1 set, a base of 0 gives 0 and a base of 1 gives 1.
- R6: With the exponent flagged signed and negative, and the base flagged signed and all ones, an exponent whose bit 0 is 1 gives all ones. An exponent whose bit 0 is 0 gives 1.
- R7: With the exponent flagged signed and negative, any other base gives 0. This includes an all-ones base that is not flagged signed.
- R8: If `start` is accepted at clock edge k, `done` rises after edge k+1 in the special cases of R2, R5, R6 and R7. Otherwise `done` rises after edge k+2+2h, where h is the index of the highest set exponent bit.
- R9: `done` is high for exactly one cycle. `result` changes only in that cycle and then holds until the next result is written.
- R10: A `start` pulse while `busy` is high is ignored: it changes neither the operation in progress, nor its timing, nor its result.
- R11: `busy` is high from the cycle after an accepted `start` up to the cycle before `done`, and is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request; captures the operands when the unit is idle |
| base_in | input | W | Base operand |
| exp_in | input | W | Exponent operand |
| base_signed | input | 1 | Read the base as two's complement |
| exp_signed | input | 1 | Read the exponent as two's complement |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: `result` has just been written |
| result | output | W | Truncated power, held between operations |

## Verification
For every accepted `start`, the reference model in the bench computes the edge on which `done` must appear. That is one edge later for a special case, and 2+2h edges later for the loop. The model counts down to that edge and gives the expected values of `busy`, `done` and `result` for every cycle. These are compared with the outputs at each falling edge, half a cycle after the registers update. The timing is therefore checked as well as the value. A `start` pulse sent during an operation is simply not accepted by the model. Any effect it has on the design shows up as a mismatch in the cycle where it occurs.

// File: rtl/pow_pkg.sv
package pow_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECIDE = 2'd1,
    ST_MULT   = 2'd2,
    ST_SQUARE = 2'd3
  } pow_state_t;
endpackage

// File: rtl/pow_trunc_mul.sv
module pow_trunc_mul #(
  parameter int W = 68
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] prod
);
  // Product kept to the operand width; upper bits are dropped.
  function automatic logic [W-1:0] trunc_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] p;
    p = a * b;
    return p;
  endfunction

  assign prod = trunc_mul(op_a, op_b);
endmodule

// File: rtl/pow_special_dec.sv
module pow_special_dec #(
  parameter int W = 68
) (
  input  logic [W-1:0] base_v,
  input  logic [W-1:0] exp_v,
  input  logic         base_sg,
  input  logic         exp_sg,
  output logic         is_special,
  output logic [W-1:0] special_val
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic exp_zero, exp_neg, base_zero, base_one, base_m1;

  always_comb begin
    exp_zero  = (exp_v == '0);
    exp_neg   = exp_sg && exp_v[W-1];
    base_zero = (base_v == '0);
    base_one  = (base_v == ONE);
    base_m1   = base_sg && (base_v == ONES);
    is_special = exp_zero || exp_neg;
    if (exp_zero)       special_val = ONE;
    else if (base_zero) special_val = '0;
    else if (base_one)  special_val = ONE;
    else if (base_m1)   special_val = exp_v[0] ? ONES : ONE;
    else                special_val = '0;
  end
endmodule

// File: rtl/int_pow_unit.sv
module int_pow_unit
  import pow_pkg::*;
#(
  parameter int W = 68
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] base_in,
  input  logic [W-1:0] exp_in,
  input  logic         base_signed,
  input  logic         exp_signed,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  pow_state_t   st;
  logic [W-1:0] base_q, exp_q, acc_q, pw_q;
  logic         bsg_q, esg_q;

  // Named internal events for the checker
  logic         accept;
  logic         last_bit;
  logic         dec_special;

  logic [W-1:0] mul_a, prod;
  logic         is_special;
  logic [W-1:0] special_val;

  assign busy     = (st != ST_IDLE);
  assign accept   = start && (st == ST_IDLE);
  assign last_bit = (exp_q[W-1:1] == '0);
  assign mul_a    = (st == ST_SQUARE) ? pw_q : acc_q;
  assign dec_special = (st == ST_DECIDE) && is_special;

  pow_trunc_mul #(.W(W)) u_mul (
    .op_a (mul_a),
    .op_b (pw_q),
    .prod (prod)
  );

  pow_special_dec #(.W(W)) u_spec (
    .base_v      (base_q),
    .exp_v       (exp_q),
    .base_sg     (bsg_q),
    .exp_sg      (esg_q),
    .is_special  (is_special),
    .special_val (special_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      done   <= 1'b0;
      result <= '0;
      base_q <= '0;
      exp_q  <= '0;
      acc_q  <= '0;
      pw_q   <= '0;
      bsg_q  <= 1'b0;
      esg_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            base_q <= base_in;
            exp_q  <= exp_in;
            bsg_q  <= base_signed;
            esg_q  <= exp_signed;
            st     <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (is_special) begin
            result <= special_val;
            done   <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            acc_q <= ONE;
            pw_q  <= base_q;
            st    <= ST_MULT;
          end
        end
        ST_MULT: begin
          if (exp_q[0]) acc_q <= prod;
          if (last_bit) begin
            result <= exp_q[0] ? prod : acc_q;
            done   <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            exp_q <= exp_q >> 1;
            st    <= ST_SQUARE;
          end
        end
        ST_SQUARE: begin
          pw_q <= prod;
          st   <= ST_MULT;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/int_pow_unit_chk.sv
module int_pow_unit_chk #(
  parameter int W = 68
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic         dec_special,
  input logic [W-1:0] op_base
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!busy && !done && result == '0));

  p_special_fast_r8: assert property (@(posedge clk) disable iff (rst)
    dec_special |=> done);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  p_ignore_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(op_base));

  p_start_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind int_pow_unit int_pow_unit_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .result      (result),
  .dec_special (dec_special),
  .op_base     (base_q)
);

// File: tb/tb_int_pow_unit.sv
module tb_int_pow_unit;
  localparam int W = 68;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] base_in = '0;
  logic [W-1:0] exp_in = '0;
  logic         base_signed = 1'b0;
  logic         exp_signed = 1'b0;
  logic         busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_pow_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .base_in(base_in), .exp_in(exp_in),
    .base_signed(base_signed), .exp_signed(exp_signed),
    .busy(busy), .done(done), .result(result)
  );

  // Reference arithmetic, most significant exponent bit first
  function automatic logic [W-1:0] ref_pow(input logic [W-1:0] b, input logic [W-1:0] e,
                                           input logic bs, input logic es);
    logic [W-1:0] r;
    if (e == '0) return 1;
    if (es && e[W-1]) begin
      if (b == '0) return '0;
      if (b == 1) return 1;
      if (bs && b == {W{1'b1}}) return e[0] ? {W{1'b1}} : 1;
      return '0;
    end
    r = 1;
    for (int i = W-1; i >= 0; i--) begin
      r = r * r;
      if (e[i]) r = r * b;
    end
    return r;
  endfunction

  function automatic int ref_lat(input logic [W-1:0] e, input logic es);
    int h;
    if (e == '0 || (es && e[W-1])) return 1;
    h = 0;
    for (int i = 0; i < W; i++) if (e[i]) h = i;
    return 2 + 2*h;
  endfunction

  // Cycle model
  bit           m_busy = 1'b0;
  bit           m_done = 1'b0;
  logic [W-1:0] m_res = '0;
  logic [W-1:0] m_pend = '0;
  int           m_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_res = '0; m_cnt = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 1'b0; m_done = 1'b1; m_res = m_pend;
        end
      end else if (start) begin
        m_busy = 1'b1;
        m_cnt  = ref_lat(exp_in, exp_signed);
        m_pend = ref_pow(base_in, exp_in, base_signed, exp_signed);
      end
    end
  end

  task automatic check(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Per-cycle comparison at the falling edge (R8, R9, R11 timing)
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(cur_req, "busy",   {{(W-1){1'b0}}, busy}, {{(W-1){1'b0}}, m_busy});
      check(cur_req, "done",   {{(W-1){1'b0}}, done}, {{(W-1){1'b0}}, m_done});
      check(cur_req, "result", result, m_res);
    end
  end

  task automatic pulse_start(input logic [W-1:0] b, input logic [W-1:0] e,
                             input logic bs, input logic es);
    @(negedge clk);
    base_in = b; exp_in = e; base_signed = bs; exp_signed = es; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [W-1:0] b, input logic [W-1:0] e,
                        input logic bs, input logic es, input logic [W-1:0] expv);
    int n;
    cur_req = req;
    pulse_start(b, e, bs, es);
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(req, "final result", result, expv);
  endtask

  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] BIGB = 68'hE123456789ABCDEF0;
  localparam logic [W-1:0] BIGE = 68'h56789ABCDEF012345;
  localparam logic [W-1:0] BIGR = 68'hCEE3CB96CE96CF000;

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset
    check("R1", "busy after reset", {{(W-1){1'b0}}, busy}, '0);
    check("R1", "done after reset", {{(W-1){1'b0}}, done}, '0);
    check("R1", "result after reset", result, '0);

    run_op("R2", '0, '0, 1'b0, 1'b0, 1);
    run_op("R2", 68'd5, '0, 1'b1, 1'b1, 1);

    run_op("R3", 68'd3, 68'd5, 1'b0, 1'b0, 68'd243);
    run_op("R3", 68'd2, 68'd67, 1'b0, 1'b0, {1'b1, {(W-1){1'b0}}});
    run_op("R3", 68'd2, 68'd68, 1'b0, 1'b0, '0);
    run_op("R3", 68'd1, ONES, 1'b0, 1'b0, 1);
    run_op("R3", ONES, 68'd3, 1'b1, 1'b0, ONES);
    run_op("R3", 68'd7, 68'd1, 1'b0, 1'b1, 68'd7);

    run_op("R4", BIGB, 68'd3, 1'b0, 1'b0, BIGR);
    run_op("R4", BIGB, 68'd3, 1'b1, 1'b1, BIGR);
    run_op("R4", BIGB, BIGE, 1'b0, 1'b0, '0);
    run_op("R4", BIGB, BIGE, 1'b1, 1'b1, '0);

    run_op("R5", '0, ONES, 1'b0, 1'b1, '0);
    run_op("R5", 68'd1, ONES - 68'd4, 1'b1, 1'b1, 1);

    run_op("R6", ONES, ONES - 68'd2, 1'b1, 1'b1, ONES);
    run_op("R6", ONES, ONES - 68'd1, 1'b1, 1'b1, 1);

    run_op("R7", 68'd7, ONES, 1'b1, 1'b1, '0);
    run_op("R7", ONES, ONES - 68'd2, 1'b0, 1'b1, '0);

    // R10: second start during the first operation must be ignored
    cur_req = "R10";
    pulse_start(68'd3, 68'd9, 1'b0, 1'b0);
    @(negedge clk);
    base_in = '0; exp_in = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int n;
      n = 0;
      while (!done && n < 400) begin
        @(negedge clk);
        n++;
      end
    end
    check("R10", "result after ignored start", result, 68'd19683);
    repeat (3) @(negedge clk);
    check("R10", "no second done", {{(W-1){1'b0}}, done}, '0);

    // R8: loop latency for exponent with highest bit 4 (2+8 edges)
    cur_req = "R8";
    pulse_start(68'd2, 68'd16, 1'b0, 1'b0);
    repeat (9) @(negedge clk);
    check("R8", "busy before due edge", {{(W-1){1'b0}}, busy}, 1);
    @(negedge clk);
    check("R8", "done on due edge", {{(W-1){1'b0}}, done}, 1);
    check("R8", "value", result, 68'd65536);
    @(negedge clk);
    check("R9", "done pulse ends", {{(W-1){1'b0}}, done}, '0);
    check("R9", "result held", result, 68'd65536);
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule